// File: doc/BRIEF.md
# Sample Rate Frequency Classifier

This block tells which of five standard audio sample rates a receiver is currently locked to. It counts pulses of a fixed 6.144 MHz reference tick over a run of 64 received frames, which is one third of a 192-frame block. It then matches the count against a window of plus or minus 4 percent around the expected count for each rate, and publishes a 3-bit rate code. A valid flag tells the consumer that the code can be trusted.

The measurement runs only while the receiver reports lock and the measurement enable is high. When either of them drops, the code and the flag clear on the next clock edge. The flag returns only after two complete measurement intervals have finished again. A block-start strobe realigns the interval to the block boundary, so the three updates per block stay in step with the incoming data. The reference tick is a qualifier on the block clock, which lets the block run from a faster system clock.

Top module: `rate_classifier`

## Requirements
- R1: After reset, `rate_code` is 000 and `rate_valid` is 0.
- R2: An interval opens on the first `frame_stb` seen while `locked` and `meas_en` are both high. It closes on the 64th `frame_stb` after that. The measured count is the number of cycles with `ref_tick` high, from the cycle after the opening strobe up to and including the closing strobe. Each nominal count maps to a code: 12288 gives 111, 8916 gives 110, 8192 gives 101, 4458 gives 100 and 4096 gives 011.
- R3: Each window covers the nominal count times 0.96, rounded up, through the nominal count times 1.04, rounded down. For the 011 code the window is 3933 to 4259 inclusive.
- R4: A count outside every window reports 000. Codes 001 and 010 are never produced.
- R5: `rate_code` changes only in the cycle after a closing strobe, or when lock or enable is lost. Between those events it holds its value.
- R6: `rate_valid` goes high together with the code published by the second consecutive complete interval since lock and enable last became true. After the first of those intervals the code is shown, but `rate_valid` stays 0.
- R7: If `locked` is low at a clock edge, `rate_code` is 000 and `rate_valid` is 0 after that edge. The interval in progress is abandoned.
- R8: If `meas_en` is low at a clock edge, the result is the same as in R7.
- R9: The tick count saturates at 32767 and does not wrap. An interval of 40960 ticks reports 000, not the 101 that a wrapped count would give.
- R10: A `frame_stb` that arrives together with `block_stb` in the middle of an interval discards the partial count and restarts the interval at that strobe, without publishing anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One pulse per reference-clock period (6.144 MHz) |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| block_stb | input | 1 | Marks a frame strobe that starts a 192-frame block |
| locked | input | 1 | Receiver lock indication |
| meas_en | input | 1 | Measurement enable |
| rate_code | output | 3 | Sample-rate code |
| rate_valid | output | 1 | Code is trustworthy |

## Verification
The hardest situation to reach is a wrapped tick count that happens to land inside a valid window. Only that case tells a saturating counter apart from a wrapping one. The stimulus closes one interval after 40960 ticks, which is 32768 plus the 48 kHz nominal count. A wrapping counter would report 48 kHz there. The window edges are reached with the same driver: it spreads any exact total over 64 strobes and puts the remainder in the last gap.

// File: rtl/rate_cls_pkg.sv
package rate_cls_pkg;

    localparam int unsigned NRATE = 5;

    localparam int unsigned RATE_HZ [NRATE] = '{32000, 44100, 48000, 88200, 96000};
    localparam logic [2:0]  RATE_CODE [NRATE] = '{3'b111, 3'b110, 3'b101, 3'b100, 3'b011};

    localparam logic [2:0] CODE_NONE = 3'b000;

    function automatic int unsigned nominal_count(int unsigned ref_hz, int unsigned frames,
                                                  int unsigned rate_hz);
        longint unsigned p;
        p = longint'(ref_hz) * longint'(frames);
        return int'(p / longint'(rate_hz));
    endfunction

    function automatic int unsigned window_lo(int unsigned n, int unsigned tol_pct);
        return int'((longint'(n) * longint'(100 - tol_pct) + 99) / 100);
    endfunction

    function automatic int unsigned window_hi(int unsigned n, int unsigned tol_pct);
        return int'((longint'(n) * longint'(100 + tol_pct)) / 100);
    endfunction

endpackage

// File: rtl/rate_tick_counter.sv
module rate_tick_counter #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] sum_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        sum_o = cnt_q;
        if (tick && cnt_q != CNT_MAX) begin
            sum_o = cnt_q + 1'b1;
        end
        cnt_d = clr ? '0 : sum_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX)
        else $error("tick counter left saturation");

endmodule

// File: rtl/rate_window_classifier.sv
module rate_window_classifier
    import rate_cls_pkg::*;
#(
    parameter int unsigned REF_HZ  = 6144000,
    parameter int unsigned FRAMES  = 64,
    parameter int unsigned TOL_PCT = 4,
    parameter int unsigned CNT_W   = 15
) (
    input  logic [CNT_W-1:0] count,
    output logic [2:0]       code
);
    logic [NRATE-1:0] hit;

    for (genvar i = 0; i < NRATE; i++) begin : g_win
        localparam int unsigned NOM = nominal_count(REF_HZ, FRAMES, RATE_HZ[i]);
        localparam logic [CNT_W-1:0] LO = CNT_W'(window_lo(NOM, TOL_PCT));
        localparam logic [CNT_W-1:0] HI = CNT_W'(window_hi(NOM, TOL_PCT));
        assign hit[i] = (count >= LO) && (count <= HI);
    end

    always_comb begin
        code = CODE_NONE;
        for (int i = NRATE - 1; i >= 0; i--) begin
            if (hit[i]) code = RATE_CODE[i];
        end
    end

endmodule

// File: rtl/rate_classifier.sv
module rate_classifier
    import rate_cls_pkg::*;
#(
    parameter int unsigned REF_HZ  = 6144000,
    parameter int unsigned FRAMES  = 64,
    parameter int unsigned TOL_PCT = 4,
    parameter int unsigned CNT_W   = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       frame_stb,
    input  logic       block_stb,
    input  logic       locked,
    input  logic       meas_en,
    output logic [2:0] rate_code,
    output logic       rate_valid
);
    localparam int unsigned FCNT_W = $clog2(FRAMES);
    localparam logic [FCNT_W-1:0] LAST_FRAME = FCNT_W'(FRAMES - 1);

    typedef struct packed {
        logic              running;
        logic [FCNT_W-1:0] fcnt;
        logic [1:0]        good;
        logic [2:0]        code;
        logic              valid;
    } state_t;

    state_t           st_d, st_q;
    logic             clr;
    logic             publish;
    logic             active;
    logic [CNT_W-1:0] sum;
    logic [2:0]       cls_code;

    rate_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .clr   (clr),
        .sum_o (sum)
    );

    rate_window_classifier #(
        .REF_HZ(REF_HZ), .FRAMES(FRAMES), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)
    ) u_cls (
        .count (sum),
        .code  (cls_code)
    );

    assign active = locked && meas_en;

    always_comb begin
        st_d    = st_q;
        clr     = 1'b0;
        publish = 1'b0;
        if (!active) begin
            st_d = '0;
            clr  = 1'b1;
        end else if (frame_stb) begin
            if (!st_q.running) begin
                st_d.running = 1'b1;
                st_d.fcnt    = '0;
                clr          = 1'b1;
            end else if (st_q.fcnt == LAST_FRAME) begin
                publish    = 1'b1;
                clr        = 1'b1;
                st_d.fcnt  = '0;
                st_d.code  = cls_code;
                st_d.valid = (st_q.good != 2'd0);
                if (st_q.good != 2'd2) st_d.good = st_q.good + 2'd1;
            end else if (block_stb) begin
                st_d.fcnt = '0;
                clr       = 1'b1;
            end else begin
                st_d.fcnt = st_q.fcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate_code  = st_q.code;
    assign rate_valid = st_q.valid;

    assert_no_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        publish |=> (rate_code != 3'b001 && rate_code != 3'b010))
        else $error("reserved code published");

    assert_code_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !publish) |=> $stable(rate_code))
        else $error("code changed without a publish");

    assert_valid_on_publish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!publish && !rate_valid) |=> !rate_valid)
        else $error("valid rose outside a publish");

    assert_unlock_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (rate_code == 3'b000 && !rate_valid))
        else $error("output kept while unlocked");

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> (rate_code == 3'b000 && !rate_valid))
        else $error("output kept while disabled");

endmodule

// File: tb/rate_classifier_test.sv
module rate_classifier_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       frame_stb = 1'b0;
    logic       block_stb = 1'b0;
    logic       locked = 1'b0;
    logic       meas_en = 1'b0;
    logic [2:0] rate_code;
    logic       rate_valid;

    rate_classifier uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .frame_stb(frame_stb),
        .block_stb(block_stb), .locked(locked), .meas_en(meas_en),
        .rate_code(rate_code), .rate_valid(rate_valid)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic [2:0] code;
        logic       valid;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   good = 0;
    logic [2:0] last_code = 3'b000;
    bit   done = 1'b0;

    function automatic logic [2:0] expect_code(int total);
        int    rates [5] = '{32000, 44100, 48000, 88200, 96000};
        logic [2:0] codes [5] = '{3'b111, 3'b110, 3'b101, 3'b100, 3'b011};
        int    c;
        real   nom;
        c = (total > 32767) ? 32767 : total;
        for (int i = 0; i < 5; i++) begin
            nom = $floor(6144000.0 * 64.0 / real'(rates[i]));
            if (real'(c) >= $ceil(nom * 0.96) && real'(c) <= $floor(nom * 1.04))
                return codes[i];
        end
        return 3'b000;
    endfunction

    task automatic push(logic [2:0] c, logic v, string tag);
        exp_t e;
        e.code = c; e.valid = v; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic strobe_after(int gap, bit blk);
        repeat (gap - 1) @(negedge clk);
        frame_stb = 1'b1;
        block_stb = blk;
        @(negedge clk);
        frame_stb = 1'b0;
        block_stb = 1'b0;
    endtask

    task automatic open_interval();
        strobe_after(3, 1'b0);
        good = 0;
    endtask

    task automatic run_interval(int total, string tag, bit midcheck = 1'b0);
        int base;
        base = total / 64;
        for (int i = 0; i < 63; i++) begin
            strobe_after(base, 1'b0);
            if (midcheck && i == 31) push(last_code, good >= 2, "R5");
        end
        strobe_after(total - 63 * base, 1'b0);
        good++;
        last_code = expect_code(total);
        push(last_code, good >= 2, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            #1;
            e = exp_q.pop_front();
            n_cmp++;
            if (rate_code !== e.code || rate_valid !== e.valid) begin
                n_bad++;
                $display("FAIL %s: code/valid actual %b/%b expected %b/%b",
                         e.tag, rate_code, rate_valid, e.code, e.valid);
            end
        end
    end

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        push(3'b000, 1'b0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        locked = 1'b1;
        meas_en = 1'b1;
        @(negedge clk);
        open_interval();
        run_interval(8192, "R6 first interval");
        run_interval(8192, "R6 second interval");
        run_interval(12288, "R2 32k");
        run_interval(8916, "R2 44.1k", 1'b1);
        run_interval(4458, "R2 88.2k");
        run_interval(4096, "R2 96k");
        run_interval(6400, "R4 between windows");
        run_interval(3933, "R3 low edge in");
        run_interval(3932, "R3 low edge out");
        run_interval(4259, "R3 high edge in");
        run_interval(4260, "R3 high edge out");
        for (int i = 0; i < 30; i++) strobe_after(200, 1'b0);
        strobe_after(128, 1'b1);
        run_interval(8192, "R10 block restart");
        run_interval(40960, "R9 saturation");
        locked = 1'b0;
        @(negedge clk);
        good = 0; last_code = 3'b000;
        push(3'b000, 1'b0, "R7");
        @(negedge clk);
        locked = 1'b1;
        open_interval();
        run_interval(4096, "R7 relock first");
        run_interval(4096, "R7 relock second");
        meas_en = 1'b0;
        @(negedge clk);
        good = 0; last_code = 3'b000;
        push(3'b000, 1'b0, "R8");
        @(negedge clk);
        meas_en = 1'b1;
        open_interval();
        run_interval(4096, "R8 re-enable first");
        run_interval(4096, "R8 re-enable second");
        wait (exp_q.size() == 0);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule